// File: doc/BRIEF.md
# Shift-and-Round Scaling Sequencer

This block scales a small unsigned value by a factor of two in either direction. It is split into a controller and a datapath. The controller is a four-state machine held in two state bits. The datapath is a row of single-bit registers, and each register's input multiplexer is selected directly by those state bits.

To run an operation, a caller presents an operand and a mode and raises start while the block is idle. The operand is captured on that edge. The next cycle doubles it (shift left) or halves it (shift right). A halving that drops a 1 bit takes one extra cycle to add one, so the quotient always rounds upward.

A one-cycle done pulse marks the last active cycle of every operation. The final value appears on the output one cycle after that pulse, and it holds while the block is idle.

Top module: `shift_round_scaler`

## Requirements
- R1: After reset, dout_o is all zeros and done_o is 0.
- R2: When the block is idle and start_i is 1 at a clock edge, dout_o equals din_i one cycle later.
- R3: With mode_i 0 at load, the next cycle shifts left with a zero entering bit 0. dout_o then becomes (din*2) mod 2^W, and done_o is 1 during that shift cycle.
- R4: With mode_i 1 at load and bit 0 of the operand equal to 0, the next cycle shifts right with a zero entering the top bit. done_o is 1 during that cycle, and dout_o then becomes din/2.
- R5: With mode_i 1 at load and bit 0 of the operand equal to 1, the shift cycle does not pulse done_o. One more cycle adds 1 and pulses done_o, and dout_o then becomes (din+1)/2.
- R6: done_o is never high for two consecutive cycles, and it is high only in the final active cycle of an operation.
- R7: While idle with start_i at 0, dout_o holds its value whatever din_i and mode_i do.
- R8: start_i, mode_i and din_i are ignored during the active cycles. If start_i is still 1 when the block returns to idle, the next operation loads at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an operation; sampled only while idle |
| mode_i | input | 1 | 0 = double, 1 = halve with round-up; sampled at load |
| din_i | input | W | Operand |
| dout_o | output | W | Register contents and result |
| done_o | output | 1 | Last active cycle of an operation |

## Verification
The round-up cycle is the hardest path to reach. It is entered only when the halving mode is combined with an odd operand, and it is the only path that runs the carry chain. The bench sweeps every operand in both modes, so every odd value exercises the extra state. The sweep includes the all-ones operand, which carries through every bit. A further run holds start high across an operation while changing the operand mid-flight. This shows that busy-state inputs are ignored and that the next load follows immediately.

// File: rtl/shift_round_scaler_pkg.sv
package shift_round_scaler_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_SHL  = 2'b01,
    ST_SHR  = 2'b10,
    ST_RND  = 2'b11
  } state_e;
endpackage

// File: rtl/srs_ctrl.sv
module srs_ctrl
  import shift_round_scaler_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   mode_i,
  input  logic   lsb_i,
  output state_e state_o,
  output logic   done_o
);
  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = mode_i ? ST_SHR : ST_SHL;
      ST_SHL:  state_d = ST_IDLE;
      ST_SHR:  state_d = lsb_i ? ST_RND : ST_IDLE;
      ST_RND:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // last active state of each path
  assign done_o  = (state_q == ST_SHL) || (state_q == ST_RND) ||
                   ((state_q == ST_SHR) && !lsb_i);
  assign state_o = state_q;
endmodule

// File: rtl/srs_bit_cell.sv
module srs_bit_cell (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  input  logic       load_i,
  input  logic       d_i,
  input  logic       lo_nb_i,
  input  logic       hi_nb_i,
  input  logic       cin_i,
  output logic       cout_o,
  output logic       q_o
);
  logic q_d;

  always_comb begin
    unique case (sel_i)
      2'b00:   q_d = load_i ? d_i : q_o;
      2'b01:   q_d = lo_nb_i;
      2'b10:   q_d = hi_nb_i;
      default: q_d = q_o ^ cin_i;
    endcase
  end

  assign cout_o = q_o & cin_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= q_d;
  end
endmodule

// File: rtl/srs_datapath.sv
module srs_datapath #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   sel_i,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int CW = W + 1;
  logic [CW-1:0] carry;
  logic [W+1:0]  ext;

  assign carry[0] = 1'b1;  // round-up increment
  assign ext      = {1'b0, q_o, 1'b0};

  for (genvar i = 0; i < W; i++) begin : g_bit
    srs_bit_cell u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sel_i   (sel_i),
      .load_i  (load_i),
      .d_i     (d_i[i]),
      .lo_nb_i (ext[i]),
      .hi_nb_i (ext[i+2]),
      .cin_i   (carry[i]),
      .cout_o  (carry[i+1]),
      .q_o     (q_o[i])
    );
  end

  logic unused_carry;
  assign unused_carry = carry[CW-1];
  logic unused_ext;
  assign unused_ext = ^{ext[0], ext[W+1]};
endmodule

// File: rtl/shift_round_scaler.sv
module shift_round_scaler
  import shift_round_scaler_pkg::*;
#(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         mode_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o,
  output logic         done_o
);
  state_e state;

  srs_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .mode_i  (mode_i),
    .lsb_i   (dout_o[0]),
    .state_o (state),
    .done_o  (done_o)
  );

  srs_datapath #(.W(W)) u_dp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (state),
    .load_i (start_i),
    .d_i    (din_i),
    .q_o    (dout_o)
  );
endmodule

// File: rtl/shift_round_scaler_chk.sv
module shift_round_scaler_chk
  import shift_round_scaler_pkg::*;
#(
  parameter int W = 3
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic [1:0]   state_i,
  input logic [W-1:0] din_i,
  input logic [W-1:0] dout_i,
  input logic         done_i
);
  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE && start_i) |=> dout_i == $past(din_i));

  a_r3_shl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_SHL) |=> dout_i == {$past(dout_i[W-2:0]), 1'b0});

  a_r4_shr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_SHR) |=> dout_i == ($past(dout_i) >> 1));

  a_r5_round: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_RND) |=> dout_i == $past(dout_i) + W'(1));

  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  a_r6_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE) |-> !done_i);

  a_r7_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE && !start_i) |=> $stable(dout_i));
endmodule

bind shift_round_scaler shift_round_scaler_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .state_i (state),
  .din_i   (din_i),
  .dout_i  (dout_o),
  .done_i  (done_o)
);

// File: tb/shift_round_scaler_tb.sv
module shift_round_scaler_tb;
  localparam int W = 3;
  localparam int N = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         mode = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;
  logic         done;
  int           n_chk = 0;
  int           n_err = 0;
  bit           finished = 1'b0;

  always #2 clk = ~clk;

  shift_round_scaler #(.W(W)) u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .start_i (start),
    .mode_i  (mode),
    .din_i   (din),
    .dout_o  (dout),
    .done_o  (done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_op(input int v, input bit m);
    int res;
    @(negedge clk);
    start = 1'b1; mode = m; din = W'(v);
    @(negedge clk);
    chk("R2 load", int'(dout), v);
    start = 1'b0; mode = ~m; din = ~W'(v);
    if (!m) begin
      chk("R3 done", int'(done), 1);
      @(negedge clk);
      chk("R3 result", int'(dout), (v * 2) % N);
      chk("R6 done low", int'(done), 0);
    end else if (v % 2 == 0) begin
      chk("R4 done", int'(done), 1);
      @(negedge clk);
      chk("R4 result", int'(dout), v / 2);
      chk("R6 done low", int'(done), 0);
    end else begin
      chk("R5 no done on shift", int'(done), 0);
      @(negedge clk);
      chk("R5 done", int'(done), 1);
      chk("R5 shifted", int'(dout), v / 2);
      @(negedge clk);
      res = (v + 1) / 2;
      chk("R5 result", int'(dout), res);
      chk("R6 done low", int'(done), 0);
    end
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 dout", int'(dout), 0);
    chk("R1 done", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int m = 0; m < 2; m++)
      for (int v = 0; v < N; v++) run_op(v, m[0]);

    // R7: idle, start low, inputs toggling
    run_op(5, 1'b0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      din = W'(k); mode = k[0];
      chk("R7 hold", int'(dout), 2);
      chk("R7 no done", int'(done), 0);
    end

    // R8: start held high across an operation, busy-cycle inputs ignored
    @(negedge clk);
    start = 1'b1; mode = 1'b0; din = 3'd3;
    @(negedge clk);
    chk("R8 load", int'(dout), 3);
    mode = 1'b1; din = 3'd5;
    @(negedge clk);
    chk("R8 shift unaffected", int'(dout), 6);
    @(negedge clk);
    chk("R8 back-to-back load", int'(dout), 5);
    start = 1'b0;
    @(negedge clk);
    chk("R8 R5 shifted", int'(dout), 2);
    chk("R8 R5 done", int'(done), 1);
    @(negedge clk);
    chk("R8 R5 result", int'(dout), 3);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule